// File: doc/BRIEF.md
# Cellular-Automaton Word Generator

This block produces a run of pseudo-random words from a one-dimensional cellular automaton. The automaton is a ring of single-bit cells. Every cell is updated at the same time from itself and its two neighbours, and the ring closes at its ends. A start pulse loads a seed together with a rule choice. The block then emits a fixed number of words on a valid/ready stream. Each word is the automaton's next generation, and each accepted word becomes the state from which the following word is computed.

The next state comes from a nonlinear three-cell rule, not from a shift register with feedback taps. Two rules are available: a plain rule and a variant with the left neighbour inverted. The rule is chosen once per run, when the run starts. After the last word is accepted, the block pulses a completion flag and goes idle, ready for another start.

Top module: `cagen_top`

## Requirements
- R1: After reset, `out_valid` and `done` are low, and no word is offered until a start is accepted.
- R2: A `start` pulse while idle loads `seed`. On the next cycle `out_valid` is high and `out_data` is one generation after the seed. The seed itself is never offered.
- R3: With `rule_sel` = 0 at start, each new cell j is `old[j-1] XOR (old[j] OR old[j+1])`. Indices wrap, so cell 0 uses bit 31 as its left neighbour and cell 31 uses bit 0 as its right neighbour. For example, seed 0x00000001 gives first word 0x80000003.
- R4: With `rule_sel` = 1 at start, each new cell j is `NOT old[j-1] XOR (old[j] OR old[j+1])`, with the same wraparound. For example, seed 0x00000001 gives 0x7FFFFFFC and seed 0x00000000 gives 0xFFFFFFFF.
- R5: Each word, once accepted (`out_valid` and `out_ready` both high on a clock edge), is the state from which the next offered word is computed, one generation later.
- R6: A run offers exactly NUM_WORDS (default 100) words, each an unsigned 32-bit value. After the last one is accepted, `out_valid` is low.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values.
- R8: `done` is high for exactly one cycle, the cycle right after the last word is accepted. It is low at all other times.
- R9: A `start` pulse while a run is in progress is ignored. The new `seed` has no effect on the words that follow.
- R10: `rule_sel` is sampled only when a start is accepted. Changing it during a run has no effect on the words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request, taken only while idle |
| rule_sel | input | 1 | 0 = plain rule, 1 = inverted-left rule, sampled at start |
| seed | input | 32 | Initial automaton state |
| out_data | output | 32 | Current generation word |
| out_valid | output | 1 | Word on `out_data` is offered |
| out_ready | input | 1 | Consumer accepts the offered word |
| done | output | 1 | One-cycle pulse after the final word is accepted |

## Verification
The bench builds the block with its default values: a 32-cell ring and 100 words per run. With these values both wrap-around neighbours at bit 0 and bit 31 are exercised in every generation, and the counter runs through its full terminal count on every run. Every word of every run is compared against a bit-loop reference model. The runs cover both rules, all-zero and all-one seeds, a stalling consumer, and a start with a changed seed and rule in the middle of a run.

// File: rtl/cagen_pkg.sv
package cagen_pkg;

    // Rule applied to every cell for the whole run.
    typedef enum logic {
        RULE_PLAIN   = 1'b0,
        RULE_INVLEFT = 1'b1
    } rule_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    // New value of one cell from its left neighbour, itself and its right neighbour.
    function automatic logic cell_next(input logic lft, input logic mid,
                                       input logic rgt, input rule_t rule);
        logic l_eff;
        l_eff = (rule == RULE_INVLEFT) ? ~lft : lft;
        return l_eff ^ (mid | rgt);
    endfunction

endpackage

// File: rtl/ca_ring_step.sv
module ca_ring_step
    import cagen_pkg::*;
#(
    parameter int CELLS = 32
) (
    input  logic [CELLS-1:0] cur,
    input  rule_t            rule,
    output logic [CELLS-1:0] nxt
);

    // One combinational cell per ring position; neighbours wrap modulo CELLS.
    for (genvar j = 0; j < CELLS; j++) begin : g_cell
        localparam int LI = (j + CELLS - 1) % CELLS;
        localparam int RI = (j + 1) % CELLS;
        assign nxt[j] = cell_next(cur[LI], cur[j], cur[RI], rule);
    end

endmodule

// File: rtl/ca_run_ctrl.sv
module ca_run_ctrl
    import cagen_pkg::*;
#(
    parameter int NUM_WORDS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ready,
    output logic busy,
    output logic load,
    output logic adv,
    output logic done
);

    localparam int CW = (NUM_WORDS > 2) ? $clog2(NUM_WORDS) : 1;
    localparam logic [CW-1:0] LAST = CW'(NUM_WORDS - 1);

    run_state_t      st_q;
    logic [CW-1:0]   cnt_q;
    logic            last_acc;

    assign busy     = (st_q == ST_RUN);
    assign load     = start && !busy;
    assign adv      = busy && ready;
    assign last_acc = adv && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= last_acc;
            if (load) begin
                st_q  <= ST_RUN;
                cnt_q <= '0;
            end else if (last_acc) begin
                st_q  <= ST_IDLE;
                cnt_q <= '0;
            end else if (adv) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R6: the word count never passes the final index
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R9: a start during a run leaves the run and its count untouched
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        busy && start && !ready |=> busy && $stable(cnt_q));

    // R8: done follows the final acceptance and returns the block to idle
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: rtl/cagen_top.sv
module cagen_top
    import cagen_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter int NUM_WORDS = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rule_sel,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] out_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             done
);

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] step_in;
    logic [WIDTH-1:0] step_out;
    rule_t            rule_q;
    rule_t            step_rule;
    logic             busy;
    logic             load;
    logic             adv;

    ca_run_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ready (out_ready),
        .busy  (busy),
        .load  (load),
        .adv   (adv),
        .done  (done)
    );

    // One ring evaluator serves both the seed load and the running state.
    assign step_in   = busy ? state_q : seed;
    assign step_rule = busy ? rule_q  : rule_t'(rule_sel);

    ca_ring_step #(.CELLS(WIDTH)) u_step (
        .cur  (step_in),
        .rule (step_rule),
        .nxt  (step_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
            rule_q  <= RULE_PLAIN;
        end else if (load) begin
            state_q <= step_out;
            rule_q  <= step_rule;
        end else if (adv) begin
            state_q <= step_out;
        end
    end

    assign out_data  = state_q;
    assign out_valid = busy;

    // R7: a stalled word is held
    a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R8: done lasts a single cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: done only after an accepted word
    a_r8_done_after_accept: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(out_valid && out_ready));

    // R2: an idle start offers a word on the next cycle
    a_r2_start_offers: assert property (@(posedge clk) disable iff (rst)
        start && !out_valid |=> out_valid);

    // R6: nothing offered while done is high
    a_r6_quiet_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);

endmodule

// File: tb/sim_cagen_top.sv
module sim_cagen_top;

    localparam int W     = 32;
    localparam int WORDS = 100;
    localparam int NVEC  = 6;

    // {rule, stall_and_inject, seed, expected first word}
    localparam logic [65:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 32'h0000_0001, 32'h8000_0003},
        {1'b1, 1'b0, 32'h0000_0001, 32'h7FFF_FFFC},
        {1'b0, 1'b1, 32'h0000_0001, 32'h8000_0003},
        {1'b1, 1'b1, 32'h0000_0000, 32'hFFFF_FFFF},
        {1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000},
        {1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         rule_sel = 1'b0;
    logic [W-1:0] seed = '0;
    logic [W-1:0] out_data;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic         done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    cagen_top #(.WIDTH(W), .NUM_WORDS(WORDS)) u0 (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rule_sel  (rule_sel),
        .seed      (seed),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .done      (done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, cycles=%0d expected < 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [W-1:0] ref_step(input logic [W-1:0] x, input logic inv);
        logic [W-1:0] y;
        for (int j = 0; j < W; j++) begin
            logic l;
            l = x[(j + W - 1) % W];
            if (inv) l = ~l;
            y[j] = l ^ (x[j] | x[(j + 1) % W]);
        end
        return y;
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_case(input logic r, input logic st,
                            input logic [W-1:0] sd, input logic [W-1:0] first);
        logic [W-1:0] model;
        logic [W-1:0] held;
        logic         was_stall;
        logic         injected;
        int           acc;
        int           cyc;
        string        wtag;
        model     = ref_step(sd, r);
        held      = '0;
        was_stall = 1'b0;
        injected  = 1'b0;
        acc       = 0;
        cyc       = 0;
        @(negedge clk);
        seed = sd; rule_sel = r; start = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(out_valid == 1'b1, "R2 valid after start", {31'd0, out_valid}, 32'd1);
        check(out_data != sd || first == sd, "R2 seed not offered", out_data, first);
        check(out_data == first, r ? "R4 first word" : "R3 first word", out_data, first);
        while (acc < WORDS && cyc < 5000) begin
            wtag = injected ? "R9/R10 word after mid-run start" : "R5 word chain";
            if (was_stall) check(out_data == held, "R7 held word", out_data, held);
            check(out_valid == 1'b1, "R6 valid during run", {31'd0, out_valid}, 32'd1);
            check(done == 1'b0, "R8 done low during run", {31'd0, done}, 32'd0);
            check(out_data == model, wtag, out_data, model);
            // R9, R10: a start with a new seed and flipped rule mid-run
            if (st && acc == 40 && !injected) begin
                start = 1'b1; seed = ~sd; rule_sel = ~r; injected = 1'b1;
            end else begin
                start = 1'b0;
            end
            out_ready = !(st && (cyc % 3 == 1));
            held      = out_data;
            was_stall = !out_ready;
            if (out_ready) begin
                model = ref_step(model, r);
                acc++;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        check(done == 1'b1, "R8 done after last word", {31'd0, done}, 32'd1);
        check(out_valid == 1'b0, "R6 no word after last", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check(done == 1'b0, "R8 done single cycle", {31'd0, done}, 32'd0);
        check(out_valid == 1'b0, "R6 idle after run", {31'd0, out_valid}, 32'd0);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state, and no word without start
        check(out_valid == 1'b0, "R1 valid after reset", {31'd0, out_valid}, 32'd0);
        check(done == 1'b0, "R1 done after reset", {31'd0, done}, 32'd0);
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 idle without start", {31'd0, out_valid}, 32'd0);
        out_ready = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            run_case(VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0]);
        end

        // R1: reset in the middle of a run clears the stream
        @(negedge clk);
        seed = 32'h0000_0001; rule_sel = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after mid-run reset", {31'd0, out_valid}, 32'd0);
        check(done == 1'b0, "R1 done after mid-run reset", {31'd0, done}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule